// File: doc/BRIEF.md
# NRZI Bit-Stuffing Serial Transmitter

This block turns a stream of bytes into a serial line for a USB-style link. A byte source hands over one packet at a time through a valid/ready interface. The source marks the final byte of the packet with a last flag. For each packet, the block first sends a fixed sync byte and then the payload bytes. Bits go out least-significant first, one bit every `CLKS_PER_BIT` clocks.

Before line coding, the bit stream passes through a stuffer. After six consecutive one bits it inserts a zero, so the line never goes without a transition for too long. While the stuffed bit is on the line, the stream from the source is held back. The coded bit then drives a pair of complementary outputs, using NRZI coding: a zero flips the level and a one keeps it. An output-enable is high for exactly as long as the packet occupies the line. Afterwards the pair returns to its idle level, with the positive line high.

The block holds one byte of buffering. At the start of a packet, the first payload byte is taken into the holding stage while the sync byte is sent. Each later byte is requested as soon as the holding stage is empty. The source has to present the next byte within one byte time. If it does not, the packet ends at the byte boundary.

Top module: `nrzi_stuff_tx`

## Requirements
- R1: After reset, and between packets, `tx_oe` is 0, `tx_dp` is 1, `tx_dn` is 0 and `in_ready` is 1.
- R2: A handshake while idle starts a packet. On the next clock edge `tx_oe` goes to 1 and the first bit of the sync byte 8'h80 appears on the line. The sync byte is sent LSB first (0,0,0,0,0,0,0,1), so the first line level is 0.
- R3: After the sync byte, the payload bytes follow in the order they were accepted, each sent LSB first. Every bit, stuffed or not, occupies exactly `CLKS_PER_BIT` clock cycles.
- R4: The line uses NRZI coding starting from the idle level 1. A 0 bit inverts `tx_dp` relative to the previous bit time, and a 1 bit keeps it unchanged.
- R5: After six consecutive 1 bits, a 0 bit is inserted. The run is counted across the sync byte and across byte boundaries. It restarts at zero after any 0 bit and after each stuffed bit.
- R6: While a stuffed bit is sent, serialization of the source data stalls and no data bit is lost. A stuffed bit that falls after the final bit of a packet is still sent before the packet ends.
- R7: `tx_dn` is always the complement of `tx_dp`.
- R8: `tx_oe` stays 1 for exactly the number of bit times of the packet, including stuffed bits. In the cycle it falls, `tx_dp` returns to 1.
- R9: Once a byte with `in_last` = 1 has been accepted, `in_ready` stays 0 until the packet has left the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source offers a byte |
| in_ready | output | 1 | Transmitter takes the offered byte on this edge |
| in_data | input | BYTE_W | Payload byte |
| in_last | input | 1 | Offered byte is the final byte of the packet |
| tx_dp | output | 1 | Positive line level |
| tx_dn | output | 1 | Negative line level, complement of `tx_dp` |
| tx_oe | output | 1 | Line driven, a packet is in flight |

## Verification
Two events can fall on the same bit boundary. A stuffed zero can be due in the very bit time in which the serializer would either reload from the holding stage or end the packet. The bench provokes the reload case with a payload of 8'hFC followed by 8'h01, and the end case with a packet made only of 8'hFC. In both, the run of ones reaches six exactly on the last bit of a byte. The bench judges the result in three ways: it compares every line level against a stream stuffed and NRZI-coded by the bench itself, it checks that `tx_oe` falls only after the extra bit time, and it checks that `in_ready` does not reopen early.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SEND = 1'b1
    } tx_phase_e;

    // Level after one NRZI bit: a zero flips, a one holds.
    function automatic logic nrzi_next(input logic level, input logic bit_in);
        return bit_in ? level : ~level;
    endfunction

endpackage

// File: rtl/nrzi_bit_timer.sv
module nrzi_bit_timer #(
    parameter int CLKS_PER_BIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] MAXV = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == MAXV) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = run && (cnt_q == MAXV);
endmodule

// File: rtl/nrzi_run_tracker.sv
module nrzi_run_tracker #(
    parameter int RUN_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic bit_val,
    output logic stuff_due
);
    localparam int OW = $clog2(RUN_LEN + 1);
    localparam logic [OW-1:0] LIMIT = OW'(RUN_LEN);

    logic [OW-1:0] ones_d, ones_q;

    always_comb begin
        ones_d = ones_q;
        if (clear) begin
            ones_d = '0;
        end else if (step) begin
            ones_d = bit_val ? ones_q + 1'b1 : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else begin
            ones_q <= ones_d;
        end
    end

    assign stuff_due = (ones_q == LIMIT);
endmodule

// File: rtl/nrzi_line_coder.sv
module nrzi_line_coder
    import nrzi_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic park,
    input  logic step,
    input  logic bit_val,
    output logic level
);
    logic level_d, level_q;

    always_comb begin
        level_d = level_q;
        if (park) begin
            level_d = 1'b1;
        end else if (step) begin
            level_d = nrzi_next(level_q, bit_val);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b1;
        end else begin
            level_q <= level_d;
        end
    end

    assign level = level_q;
endmodule

// File: rtl/nrzi_stuff_tx.sv
module nrzi_stuff_tx
    import nrzi_tx_pkg::*;
#(
    parameter int              BYTE_W       = 8,
    parameter int              CLKS_PER_BIT = 4,
    parameter int              RUN_LEN      = 6,
    parameter logic [BYTE_W-1:0] SYNC_BYTE  = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              tx_dp,
    output logic              tx_dn,
    output logic              tx_oe
);
    localparam int IW = $clog2(BYTE_W);
    localparam logic [IW-1:0] LAST_IDX = IW'(BYTE_W - 1);

    typedef struct packed {
        tx_phase_e         phase;
        logic [BYTE_W-1:0] shift;
        logic [IW-1:0]     idx;
        logic              cur_last;
        logic [BYTE_W-1:0] hold;
        logic              hold_full;
        logic              hold_last;
        logic              last_taken;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        phase:      PH_IDLE,
        shift:      '0,
        idx:        '0,
        cur_last:   1'b0,
        hold:       '0,
        hold_full:  1'b0,
        hold_last:  1'b0,
        last_taken: 1'b0
    };

    seq_t seq_d, seq_q;

    logic bit_tick;
    logic stuff_due;
    logic line_level;
    logic step;
    logic step_bit;
    logic park;
    logic accept;

    nrzi_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (seq_q.phase == PH_SEND),
        .tick  (bit_tick)
    );

    nrzi_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (park),
        .step      (step),
        .bit_val   (step_bit),
        .stuff_due (stuff_due)
    );

    nrzi_line_coder u_coder (
        .clk     (clk),
        .rst_n   (rst_n),
        .park    (park),
        .step    (step),
        .bit_val (step_bit),
        .level   (line_level)
    );

    assign in_ready = (seq_q.phase == PH_IDLE) || (!seq_q.hold_full && !seq_q.last_taken);
    assign accept   = in_valid && in_ready;

    always_comb begin
        seq_d    = seq_q;
        step     = 1'b0;
        step_bit = 1'b0;
        park     = 1'b0;

        if (seq_q.phase == PH_IDLE) begin
            if (accept) begin
                seq_d.phase      = PH_SEND;
                seq_d.shift      = SYNC_BYTE;
                seq_d.idx        = '0;
                seq_d.cur_last   = 1'b0;
                seq_d.hold       = in_data;
                seq_d.hold_full  = 1'b1;
                seq_d.hold_last  = in_last;
                seq_d.last_taken = in_last;
                step             = 1'b1;
                step_bit         = SYNC_BYTE[0];
            end
        end else begin
            if (accept) begin
                seq_d.hold       = in_data;
                seq_d.hold_full  = 1'b1;
                seq_d.hold_last  = in_last;
                seq_d.last_taken = seq_q.last_taken | in_last;
            end
            if (bit_tick) begin
                if (stuff_due) begin
                    // stuffed zero; shifter and index stay put
                    step     = 1'b1;
                    step_bit = 1'b0;
                end else if (seq_q.idx != LAST_IDX) begin
                    seq_d.shift = seq_q.shift >> 1;
                    seq_d.idx   = seq_q.idx + 1'b1;
                    step        = 1'b1;
                    step_bit    = seq_q.shift[1];
                end else if (seq_q.cur_last || !seq_q.hold_full) begin
                    seq_d.phase      = PH_IDLE;
                    seq_d.hold_full  = 1'b0;
                    seq_d.last_taken = 1'b0;
                    park             = 1'b1;
                end else begin
                    seq_d.shift     = seq_q.hold;
                    seq_d.idx       = '0;
                    seq_d.cur_last  = seq_q.hold_last;
                    seq_d.hold_full = 1'b0;
                    step            = 1'b1;
                    step_bit        = seq_q.hold[0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign tx_dp = line_level;
    assign tx_dn = ~line_level;
    assign tx_oe = (seq_q.phase == PH_SEND);
endmodule

// File: rtl/nrzi_tx_checker.sv
module nrzi_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic in_last,
    input logic tx_dp,
    input logic tx_dn,
    input logic tx_oe,
    input logic bit_tick,
    input logic stuff_due
);
    assert_pair_complement_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dn == !tx_dp);

    assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> tx_dp);

    assert_start_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_oe && in_valid && in_ready) |=> (tx_oe && !tx_dp));

    assert_bit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_oe && $past(tx_oe) && !$past(bit_tick)) |-> $stable(tx_dp));

    assert_stuff_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && stuff_due) |=> (tx_oe && (tx_dp != $past(tx_dp))));

    assert_no_ready_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready);
endmodule

bind nrzi_stuff_tx nrzi_tx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .tx_dp     (tx_dp),
    .tx_dn     (tx_dn),
    .tx_oe     (tx_oe),
    .bit_tick  (bit_tick),
    .stuff_due (stuff_due)
);

// File: tb/nrzi_stuff_tx_bench.sv
`timescale 1ns/1ps
module nrzi_stuff_tx_bench;
    localparam int C  = 3;
    localparam int NV = 7;

    // payload bytes (byte k at [8k+:8]), byte count, gap before each later byte
    localparam logic [31:0] VEC_BYTES [NV] = '{32'h00, 32'hFF, 32'hFFFF, 32'hFC,
                                               32'h01FC, 32'hC33C5AA5, 32'h1F};
    localparam int VEC_LEN [NV] = '{1, 1, 2, 1, 2, 4, 1};
    localparam int VEC_GAP [NV] = '{0, 0, 5, 0, 10, 2, 0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       tx_dp, tx_dn, tx_oe;

    int checks = 0;
    int errors = 0;
    logic exp_lvl [0:255];
    int   exp_n;

    always #5 clk = ~clk;

    nrzi_stuff_tx #(.CLKS_PER_BIT(C)) u_nrzi_stuff_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last),
        .tx_dp(tx_dp), .tx_dn(tx_dn), .tx_oe(tx_oe)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push_bit(input logic b, inout int ones, inout logic lvl);
        lvl = b ? lvl : ~lvl;
        exp_lvl[exp_n] = lvl;
        exp_n++;
        ones = b ? ones + 1 : 0;
        if (ones == 6) begin
            lvl = ~lvl;                 // stuffed zero
            exp_lvl[exp_n] = lvl;
            exp_n++;
            ones = 0;
        end
    endtask

    task automatic build(input int v);
        int   ones = 0;
        logic lvl  = 1'b1;
        logic [7:0] b;
        exp_n = 0;
        for (int i = 0; i < 8; i++) push_bit(((8'h80 >> i) & 1) != 0, ones, lvl);
        for (int k = 0; k < VEC_LEN[v]; k++) begin
            b = VEC_BYTES[v][8*k +: 8];
            for (int i = 0; i < 8; i++) push_bit(b[i], ones, lvl);
        end
    endtask

    task automatic send_pkt(input int v);
        for (int k = 0; k < VEC_LEN[v]; k++) begin
            if (k > 0) repeat (VEC_GAP[v]) @(negedge clk);
            in_valid = 1'b1;
            in_data  = VEC_BYTES[v][8*k +: 8];
            in_last  = (k == VEC_LEN[v] - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            if (k == 0) begin
                chk(tx_oe == 1'b1, "R2 oe after start", tx_oe, 1);
                chk(tx_dp == 1'b0, "R2 first sync level", tx_dp, 0);
            end
            if (k == VEC_LEN[v] - 1)
                chk(in_ready == 1'b0, "R9 ready after last", in_ready, 0);
        end
        in_last = 1'b0;
    endtask

    task automatic watch_pkt(input int v);
        while (!tx_oe) @(negedge clk);
        for (int i = 0; i < exp_n; i++) begin
            chk(tx_dp == exp_lvl[i], $sformatf("R3 R4 R5 R6 vec%0d bit%0d", v, i), tx_dp, exp_lvl[i]);
            chk(tx_dn == ~tx_dp, "R7 complement", tx_dn, ~tx_dp);
            chk(tx_oe == 1'b1, "R8 oe during packet", tx_oe, 1);
            repeat (C) @(negedge clk);
        end
        chk(tx_oe == 1'b0, "R8 oe after packet", tx_oe, 0);
        chk(tx_dp == 1'b1 && tx_dn == 1'b0, "R8 idle level", tx_dp, 1);
        chk(in_ready == 1'b1, "R1 ready between packets", in_ready, 1);
    endtask

    task automatic run_vec(input int v);
        build(v);
        fork
            send_pkt(v);
            watch_pkt(v);
        join
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_oe == 1'b0, "R1 reset oe", tx_oe, 0);
        chk(tx_dp == 1'b1, "R1 reset dp", tx_dp, 1);
        chk(tx_dn == 1'b0, "R1 reset dn", tx_dn, 0);
        chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);

        for (int v = 0; v < NV; v++) run_vec(v);

        // reset in the middle of a packet returns the line to idle (R1)
        in_valid = 1'b1; in_data = 8'hFF; in_last = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_oe == 1'b0, "R1 oe after mid reset", tx_oe, 0);
        chk(tx_dp == 1'b1 && tx_dn == 1'b0, "R1 level after mid reset", tx_dp, 1);
        chk(in_ready == 1'b1, "R1 ready after mid reset", in_ready, 1);

        // stuff bit at a byte boundary once more after recovery (R6)
        run_vec(4);
        run_vec(3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule